// File: doc/BRIEF.md
# Opcode-Tagged Panel Command Sequencer

This block walks a program store of 10-bit words and turns them into the control side of a serial TFT panel link. Each word carries a 2-bit opcode above an 8-bit payload. The block decodes the opcode into the chip-select and data/command levels, hands the payload byte to an external serializer, runs a fixed pause on wait words, and stops on an end word. The program counter drives the read address of an external synchronous ROM that has one cycle of read latency.

A strobe `slot_i` arrives once per byte slot, that is, once every eight serial clocks. Each accepted strobe executes the word currently on `rom_data_i`. After system reset the panel reset line is held low for a parameterized number of clocks. Only then does execution begin. In this way one program image can hold the panel setup sequence and a full 160×128 frame at two bytes per pixel. That is 40960 bytes plus the setup words, so the address must be at least 16 bits wide.

Top module: `lcd_opseq`

## Requirements
- R1: A program word holds its opcode in bits [9:8] and its payload in bits [7:0]. When `load_o` is high, `byte_o` equals the payload of the executed word.
- R2: Opcode 0 (data) drives `dc_o` high and `cs_n_o` low. It also pulses `load_o` in the cycle after the accepted strobe.
- R3: Opcode 1 (command) drives `dc_o` low and `cs_n_o` low, and pulses `load_o` in the same way.
- R4: Opcode 2 (wait) drives `cs_n_o` high and produces no load. It holds `pc_en_o` low for exactly `DELAY_CYCLES` clocks, with `rom_addr_o` held. The address then advances by one. Every wait has the same length.
- R5: `load_o` is high for one clock at a time, and only for opcodes 0 and 1. While it is high, `rom_addr_o` equals the executed word's address plus one.
- R6: `dc_o` and `cs_n_o` keep the levels of the last loaded byte until the next word executes, even though the following word has already been fetched.
- R7: Opcode 3 (end) raises `done_o` and keeps it high until reset. It forces `cs_n_o` high and freezes the address. Later strobes produce no loads.
- R8: `panel_rst_n_o` rises on the `RST_CYCLES`-th rising clock edge after `rst_n` is released. Strobes before that are ignored.
- R9: During reset `cs_n_o`=1, `load_o`=0, `done_o`=0, `pc_en_o`=1, `panel_rst_n_o`=0 and `rom_addr_o`=0.
- R10: A strobe that arrives during a wait is ignored. A word is used only after its address has been stable for one full clock, which accounts for the ROM latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | One-cycle byte-slot strobe |
| rom_addr_o | output | AW | Program ROM read address |
| rom_data_i | input | 10 | ROM word, valid one clock after the address |
| byte_o | output | 8 | Payload byte for the serializer |
| load_o | output | 1 | Serializer load pulse |
| dc_o | output | 1 | Data/command select (1 = data) |
| cs_n_o | output | 1 | Panel chip select, active low |
| panel_rst_n_o | output | 1 | Panel reset, active low |
| pc_en_o | output | 1 | Program counter enable; low during a wait |
| done_o | output | 1 | Program finished |

## Verification
The main program mixes command words, data words and two waits. The two waits sit in different positions, one after a command and one between a command and data. This shows whether the data/command level follows the opcode rather than the position of the word, and whether a strobe that falls inside a wait is dropped. Back-to-back data bytes with distinct payloads (0x05, 0xA5, 0xFF, 0x00) expose swapped or stale payload bits. A second program that starts with an end word, together with a strobe sent while the panel is still in reset, shows whether strobes before the release are ignored and whether a program can terminate on its very first word.

// File: rtl/lcd_opseq_pkg.sv
package lcd_opseq_pkg;
   localparam int WORD_W    = 10;
   localparam int PAYLOAD_W = 8;
   localparam int OP_W      = 2;

   typedef enum logic [OP_W-1:0] {
      OP_DATA = 2'd0,
      OP_CMD  = 2'd1,
      OP_WAIT = 2'd2,
      OP_END  = 2'd3
   } op_e;

   function automatic op_e word_op(input logic [WORD_W-1:0] w);
      return op_e'(w[WORD_W-1 -: OP_W]);
   endfunction

   function automatic logic [PAYLOAD_W-1:0] word_payload(input logic [WORD_W-1:0] w);
      return w[PAYLOAD_W-1:0];
   endfunction
endpackage

// File: rtl/lcd_opseq_rstgen.sv
module lcd_opseq_rstgen #(
   parameter int RST_CYCLES = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic released_o
);
   localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

   logic [CW-1:0] cnt_q;
   logic          rel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= 1'b0;
      end else if (!rel_q) begin
         if (cnt_q == CW'(RST_CYCLES - 1)) rel_q <= 1'b1;
         else                              cnt_q <= cnt_q + 1'b1;
      end
   end

   assign released_o = rel_q;
endmodule

// File: rtl/lcd_opseq_fetch.sv
module lcd_opseq_fetch #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   output logic [AW-1:0] addr_o,
   output logic          word_ok_o
);
   logic [AW-1:0] pc_q;
   logic          settle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= '0;
         settle_q <= 1'b1;
      end else begin
         settle_q <= adv_i;
         if (adv_i) pc_q <= pc_q + 1'b1;
      end
   end

   assign addr_o    = pc_q;
   assign word_ok_o = !settle_q;
endmodule

// File: rtl/lcd_opseq_exec.sv
module lcd_opseq_exec
   import lcd_opseq_pkg::*;
#(
   parameter int DELAY_CYCLES = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_i,
   input  logic                 slot_i,
   input  logic                 word_ok_i,
   input  logic [WORD_W-1:0]    word_i,
   output logic                 adv_o,
   output logic [PAYLOAD_W-1:0] byte_o,
   output logic                 load_o,
   output logic                 dc_o,
   output logic                 cs_n_o,
   output logic                 wait_o,
   output logic                 done_o
);
   localparam int DW = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES);

   op_e     op;
   logic    take;
   logic    wait_last;
   logic [DW-1:0] dly_q;
   logic    wait_q, done_q;

   assign op        = word_op(word_i);
   assign take      = slot_i && run_i && word_ok_i && !wait_q && !done_q;
   assign wait_last = wait_q && (dly_q == '0);
   assign adv_o     = (take && (op == OP_DATA || op == OP_CMD)) || wait_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_o <= '0;
         load_o <= 1'b0;
         dc_o   <= 1'b1;
         cs_n_o <= 1'b1;
         wait_q <= 1'b0;
         dly_q  <= '0;
         done_q <= 1'b0;
      end else begin
         load_o <= 1'b0;
         if (wait_q) begin
            if (wait_last) wait_q <= 1'b0;
            else           dly_q  <= dly_q - 1'b1;
         end
         if (take) begin
            unique case (op)
               OP_DATA, OP_CMD: begin
                  byte_o <= word_payload(word_i);
                  dc_o   <= (op == OP_DATA);
                  cs_n_o <= 1'b0;
                  load_o <= 1'b1;
               end
               OP_WAIT: begin
                  cs_n_o <= 1'b1;
                  wait_q <= 1'b1;
                  dly_q  <= DW'(DELAY_CYCLES - 1);
               end
               OP_END: begin
                  cs_n_o <= 1'b1;
                  done_q <= 1'b1;
               end
            endcase
         end
      end
   end

   assign wait_o = wait_q;
   assign done_o = done_q;
endmodule

// File: rtl/lcd_opseq.sv
module lcd_opseq
   import lcd_opseq_pkg::*;
#(
   parameter int AW           = 16,
   parameter int RST_CYCLES   = 5,
   parameter int DELAY_CYCLES = 20,
   parameter int FRAME_BYTES  = 40960,
   parameter int INIT_WORDS   = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_i,
   output logic [AW-1:0]        rom_addr_o,
   input  logic [WORD_W-1:0]    rom_data_i,
   output logic [PAYLOAD_W-1:0] byte_o,
   output logic                 load_o,
   output logic                 dc_o,
   output logic                 cs_n_o,
   output logic                 panel_rst_n_o,
   output logic                 pc_en_o,
   output logic                 done_o
);
   localparam longint NEED_WORDS = longint'(FRAME_BYTES) + longint'(INIT_WORDS);

   generate
      if (AW < 1 || AW > 32) begin : g_bad_aw
         $error("lcd_opseq: AW out of range");
      end
      if ((longint'(1) << AW) < NEED_WORDS) begin : g_small_aw
         $error("lcd_opseq: address space cannot hold frame plus setup words");
      end
      if (DELAY_CYCLES < 1) begin : g_bad_dly
         $error("lcd_opseq: DELAY_CYCLES must be at least 1");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("lcd_opseq: RST_CYCLES must be at least 1");
      end
   endgenerate

   logic released, adv, word_ok, waiting;

   lcd_opseq_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .released_o (released)
   );

   lcd_opseq_fetch #(.AW(AW)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .addr_o    (rom_addr_o),
      .word_ok_o (word_ok)
   );

   lcd_opseq_exec #(.DELAY_CYCLES(DELAY_CYCLES)) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (released),
      .slot_i    (slot_i),
      .word_ok_i (word_ok),
      .word_i    (rom_data_i),
      .adv_o     (adv),
      .byte_o    (byte_o),
      .load_o    (load_o),
      .dc_o      (dc_o),
      .cs_n_o    (cs_n_o),
      .wait_o    (waiting),
      .done_o    (done_o)
   );

   assign panel_rst_n_o = released;
   assign pc_en_o       = !waiting;
endmodule

// File: rtl/lcd_opseq_chk.sv
module lcd_opseq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_o,
   input logic          cs_n_o,
   input logic          done_o,
   input logic          panel_rst_n_o,
   input logic          pc_en_o,
   input logic [AW-1:0] rom_addr_o
);
   assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);

   assert_load_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> rom_addr_o == AW'($past(rom_addr_o) + 1'b1));

   assert_load_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> !cs_n_o);

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o && $stable(rom_addr_o));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cs_n_o && !load_o);

   assert_panel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst_n_o |-> cs_n_o && !load_o && pc_en_o);

   assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_en_o |-> cs_n_o && !load_o);

   assert_wait_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_en_o |=> pc_en_o || $stable(rom_addr_o));
endmodule

bind lcd_opseq lcd_opseq_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .load_o        (load_o),
   .cs_n_o        (cs_n_o),
   .done_o        (done_o),
   .panel_rst_n_o (panel_rst_n_o),
   .pc_en_o       (pc_en_o),
   .rom_addr_o    (rom_addr_o)
);

// File: tb/sim_lcd_opseq.sv
module sim_lcd_opseq;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int RSTC = 5;
   localparam int DLY  = 20;
   localparam int ROM_N = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_i = 1'b0;
   logic [AW-1:0] rom_addr_o;
   logic [9:0]    rom_data_i;
   logic [7:0]    byte_o;
   logic          load_o, dc_o, cs_n_o, panel_rst_n_o, pc_en_o, done_o;

   logic [9:0] rom [ROM_N];

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) rom_data_i <= rom[rom_addr_o[5:0]];

   lcd_opseq #(.AW(AW), .RST_CYCLES(RSTC), .DELAY_CYCLES(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .slot_i(slot_i),
      .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
      .byte_o(byte_o), .load_o(load_o), .dc_o(dc_o), .cs_n_o(cs_n_o),
      .panel_rst_n_o(panel_rst_n_o), .pc_en_o(pc_en_o), .done_o(done_o)
   );

   int total = 0;
   int bad   = 0;
   logic [24:0] exp_q[$];
   int loads = 0;
   bit mon_on = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver side: store a word and push the expected serializer item
   task automatic put(input int idx, input logic [1:0] op, input logic [7:0] pl);
      rom[idx] = {op, pl};
      if (op == 2'd0 || op == 2'd1)
         exp_q.push_back({16'(idx + 1), (op == 2'd0), pl});
   endtask

   task automatic slot_pulse();
      repeat (15) @(negedge clk);
      slot_i = 1'b1;
      @(negedge clk);
      slot_i = 1'b0;
   endtask

   // monitor / scoreboard
   logic        last_dc = 1'b1;
   int          lowcnt = 0;
   logic [AW-1:0] hold_addr = '0;
   bit          wait_bad = 0;
   int          wait_slots = 0;
   int          waits_seen = 0;

   always @(negedge clk) if (mon_on) begin
      if (load_o) begin
         loads++;
         if (exp_q.size() == 0) chk(0, "R5 unexpected load", int'(byte_o), 0);
         else begin
            logic [24:0] e;
            e = exp_q.pop_front();
            chk(byte_o == e[7:0], "R1 payload", int'(byte_o), int'(e[7:0]));
            chk(dc_o == e[8], e[8] ? "R2 data dc" : "R3 command dc", int'(dc_o), int'(e[8]));
            chk(cs_n_o == 1'b0, "R2 R3 select low", int'(cs_n_o), 0);
            chk(rom_addr_o == e[24:9], "R5 address", int'(rom_addr_o), int'(e[24:9]));
         end
         last_dc = dc_o;
      end
      if (slot_i && loads > 0 && pc_en_o && !done_o)
         chk(dc_o == last_dc, "R6 dc held", int'(dc_o), int'(last_dc));
      if (!pc_en_o) begin
         if (lowcnt == 0) hold_addr = rom_addr_o;
         else if (rom_addr_o != hold_addr) wait_bad = 1;
         if (load_o || !cs_n_o) wait_bad = 1;
         if (slot_i) wait_slots++;
         lowcnt++;
      end else if (lowcnt > 0) begin
         waits_seen++;
         chk(lowcnt == DLY, "R4 wait length", lowcnt, DLY);
         chk(rom_addr_o == hold_addr + 1'b1, "R4 advance", int'(rom_addr_o), int'(hold_addr) + 1);
         chk(!wait_bad, "R10 wait ignored strobes", int'(wait_bad), 0);
         lowcnt = 0;
         wait_bad = 0;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int k;
      for (int i = 0; i < ROM_N; i++) rom[i] = 10'h300;
      put(0, 2'd1, 8'h01);
      put(1, 2'd2, 8'h00);
      put(2, 2'd1, 8'h3A);
      put(3, 2'd0, 8'h05);
      put(4, 2'd0, 8'hA5);
      put(5, 2'd1, 8'h2C);
      put(6, 2'd2, 8'h00);
      put(7, 2'd0, 8'hFF);
      put(8, 2'd0, 8'h00);
      put(9, 2'd3, 8'h00);

      repeat (3) @(negedge clk);
      // R9 reset state
      chk(cs_n_o == 1 && load_o == 0 && done_o == 0, "R9 reset outputs", {cs_n_o, load_o, done_o}, 3'b100);
      chk(pc_en_o == 1 && panel_rst_n_o == 0, "R9 reset pc_en/panel", {pc_en_o, panel_rst_n_o}, 2'b10);
      chk(rom_addr_o == 0, "R9 reset address", int'(rom_addr_o), 0);

      rst_n = 1'b1;
      mon_on = 1;
      k = 0;
      while (!panel_rst_n_o && k < 100) begin
         @(negedge clk);
         k++;
      end
      chk(k == RSTC, "R8 panel reset length", k, RSTC);

      for (int n = 0; n < 60 && !done_o; n++) slot_pulse();
      repeat (3) @(negedge clk);
      chk(done_o == 1, "R7 done raised", int'(done_o), 1);
      chk(cs_n_o == 1, "R7 select released", int'(cs_n_o), 1);
      chk(rom_addr_o == 9, "R7 address at end word", int'(rom_addr_o), 9);
      chk(waits_seen == 2, "R4 waits executed", waits_seen, 2);
      chk(wait_slots > 0, "R10 strobe landed in wait", wait_slots, 1);
      k = loads;
      for (int n = 0; n < 3; n++) slot_pulse();
      repeat (3) @(negedge clk);
      chk(loads == k && loads == 7, "R7 no loads after end", loads, 7);
      chk(done_o == 1 && rom_addr_o == 9, "R7 done sticky", int'(rom_addr_o), 9);
      chk(exp_q.size() == 0, "R5 all items seen", exp_q.size(), 0);

      // second program: end word at address 0, strobe during panel reset
      mon_on = 0;
      rst_n = 1'b0;
      rom[0] = 10'h300;
      repeat (3) @(negedge clk);
      chk(done_o == 0 && rom_addr_o == 0, "R9 re-reset", int'(done_o), 0);
      rst_n = 1'b1;
      mon_on = 1;
      k = loads;
      @(negedge clk);
      @(negedge clk);
      slot_i = 1'b1;
      @(negedge clk);
      slot_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(done_o == 0, "R8 strobe before release ignored", int'(done_o), 0);
      repeat (RSTC) @(negedge clk);
      slot_pulse();
      repeat (2) @(negedge clk);
      chk(done_o == 1 && cs_n_o == 1, "R7 end as first word", int'(done_o), 1);
      chk(loads == k && rom_addr_o == 0, "R7 no load, address frozen", int'(rom_addr_o), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule